// File: doc/BRIEF.md
# ADC Output Formatter and Double-Rate Lane Packer

This block sits between the converter core of one channel and its output pins. Every sample clock it accepts a 16-bit offset-binary sample and two overrange flags: a normal flag that marks a code beyond full scale, and a fast flag raised by the core's threshold comparator. It converts the sample to the selected number format, optionally reverses its bit order, and splits the word across eight double-rate lanes. Each lane carries one even-numbered bit in the rising-edge phase and the next odd-numbered bit in the falling-edge phase.

The two flags reach the pins with different latencies. The normal flag stays in step with its data word, and the fast flag arrives five sample clocks earlier. Either flag can also replace the lowest lane, so a receiver with no spare pins still sees overrange. A channel-disable input clears a registered output enable that drives the pad tri-state control.

Top module: `adc_ddr_formatter`

## Requirements
- R1: While `rst_n` is low, all lane outputs, both flag pins and `lane_oe` are 0.
- R2: A sample applied before clock edge n is reflected on `lane_rise`/`lane_fall` right after edge n+13 (DATA_LAT = 14 registers counting the capture edge). The normal flag applied with it appears on `ovr_norm_pin` in the same cycle.
- R3: The fast flag applied before edge n appears on `ovr_fast_pin` right after edge n+8 (FAST_LAT = 9), which is 5 clocks ahead of the data word.
- R4: With `fmt_offset` = 1 the offset-binary input word passes unchanged. With `fmt_offset` = 0 the output is twos complement, formed by inverting bit 15.
- R5: With `bit_flip` = 1 the formatted word is reversed, so bit i moves to position 15-i. The reversal is applied after the format conversion.
- R6: Lane k carries bit 2k of the final word in `lane_rise[k]` and bit 2k+1 in `lane_fall[k]`.
- R7: With `lsb_mode` = 2'b01, lane 0 carries the fast flag in both phases. This is the same value that `ovr_fast_pin` shows in that cycle.
- R8: With `lsb_mode` = 2'b10, lane 0 carries the normal flag in both phases. This is the value `ovr_norm_pin` shows in that cycle, aligned with its data word.
- R9: With `lsb_mode` = 2'b00 or 2'b11, lane 0 carries data bits 0 and 1 as in R6.
- R10: After each clock edge `lane_oe` equals the inverse of `ch_disable` sampled at that edge. While disabled, the lane registers keep producing data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_code | input | 16 | Offset-binary sample from the converter core |
| ovr_norm_in | input | 1 | Normal overrange flag for this sample |
| ovr_fast_in | input | 1 | Fast threshold-crossing flag |
| fmt_offset | input | 1 | 1: offset binary out, 0: twos complement |
| bit_flip | input | 1 | Reverse bit order of the output word |
| lsb_mode | input | 2 | Lane-0 source: 01 fast flag, 10 normal flag, else data |
| ch_disable | input | 1 | Request high impedance on this channel's lanes |
| lane_rise | output | 8 | Rising-edge phase bits, one per lane |
| lane_fall | output | 8 | Falling-edge phase bits, one per lane |
| ovr_norm_pin | output | 1 | Normal overrange, aligned with data |
| ovr_fast_pin | output | 1 | Fast overrange, 5 clocks ahead of data |
| lane_oe | output | 1 | Output enable for the lane pads |

## Verification
The bound checker checks several properties on every cycle: the quiet outputs during reset, the one-edge response of `lane_oe` to the disable input, and the equality of lane 0 in both phases with the chosen flag pin whenever a flag-insertion mode is held. The checker cannot see the arithmetic content of a word or the 14- and 9-clock alignments. The scoreboard scenarios cover those: format conversion, reversal, lane interleaving, the offset between fast flag and data, and data pass-through in both data-keeping codes, using corner samples and a pseudo-random stream.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
  // Lane-0 source selection; codes 00 and 11 both keep data bits.
  typedef enum logic [1:0] {
    LSB_KEEP_LO = 2'b00,
    LSB_FAST    = 2'b01,
    LSB_NORM    = 2'b10,
    LSB_KEEP_HI = 2'b11
  } lsb_sel_e;
endpackage

// File: rtl/adcfmt_delay.sv
// Plain shift-register delay line of DEPTH flops (DEPTH = 0 is a wire).
module adcfmt_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_pipe
      logic [W-1:0] pipe_d [DEPTH];
      logic [W-1:0] pipe_q [DEPTH];

      always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < DEPTH; i++) pipe_d[i] = pipe_q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
        end else begin
          for (int i = 0; i < DEPTH; i++) pipe_q[i] <= pipe_d[i];
        end
      end

      assign q = pipe_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/adcfmt_shaper.sv
// One register stage: number format first, then optional bit reversal.
module adcfmt_shaper #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  input  logic         fmt_offset,
  input  logic         bit_flip,
  output logic [W-1:0] word_q
);
  logic [W-1:0] conv;
  logic [W-1:0] rev;
  logic [W-1:0] word_d;

  always_comb begin
    conv = raw;
    if (!fmt_offset) conv[W-1] = ~raw[W-1];
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_rev
      assign rev[i] = conv[W-1-i];
    end
  endgenerate

  always_comb word_d = bit_flip ? rev : conv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end
endmodule

// File: rtl/adcfmt_lane_pack.sv
// Final register stage: even/odd split per lane, lane-0 flag insertion,
// flag pins and pad enable.
module adcfmt_lane_pack
  import adcfmt_pkg::*;
#(
  parameter int W = 16,
  localparam int L = W / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] word,
  input  logic         norm_flag,
  input  logic         fast_flag,
  input  logic [1:0]   lsb_mode,
  input  logic         ch_disable,
  output logic [L-1:0] rise_q,
  output logic [L-1:0] fall_q,
  output logic         norm_pin_q,
  output logic         fast_pin_q,
  output logic         oe_q
);
  logic [L-1:0] rise_d;
  logic [L-1:0] fall_d;

  always_comb begin
    for (int k = 0; k < L; k++) begin
      rise_d[k] = word[2*k];
      fall_d[k] = word[2*k+1];
    end
    case (lsb_sel_e'(lsb_mode))
      LSB_FAST: begin
        rise_d[0] = fast_flag;
        fall_d[0] = fast_flag;
      end
      LSB_NORM: begin
        rise_d[0] = norm_flag;
        fall_d[0] = norm_flag;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q     <= '0;
      fall_q     <= '0;
      norm_pin_q <= 1'b0;
      fast_pin_q <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      rise_q     <= rise_d;
      fall_q     <= fall_d;
      norm_pin_q <= norm_flag;
      fast_pin_q <= fast_flag;
      oe_q       <= ~ch_disable;
    end
  end
endmodule

// File: rtl/adc_ddr_formatter.sv
module adc_ddr_formatter #(
  parameter int WORD_W   = 16,
  parameter int DATA_LAT = 14,
  parameter int FAST_LAT = 9,
  localparam int LANES   = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] smp_code,
  input  logic              ovr_norm_in,
  input  logic              ovr_fast_in,
  input  logic              fmt_offset,
  input  logic              bit_flip,
  input  logic [1:0]        lsb_mode,
  input  logic              ch_disable,
  output logic [LANES-1:0]  lane_rise,
  output logic [LANES-1:0]  lane_fall,
  output logic              ovr_norm_pin,
  output logic              ovr_fast_pin,
  output logic              lane_oe
);
  // Data: padding + shaper + pack = DATA_LAT registers.
  localparam int DATA_PAD = DATA_LAT - 2;
  // Normal flag: padding + pack = DATA_LAT registers.
  localparam int NORM_PAD = DATA_LAT - 1;
  // Fast flag: padding + pack = FAST_LAT registers.
  localparam int FAST_PAD = FAST_LAT - 1;

  logic [WORD_W-1:0] raw_dly;
  logic [WORD_W-1:0] shaped;
  logic              norm_dly;
  logic              fast_dly;

  adcfmt_delay #(.W(WORD_W), .DEPTH(DATA_PAD)) u_data_dly (
    .clk(clk), .rst_n(rst_n), .d(smp_code), .q(raw_dly)
  );

  adcfmt_delay #(.W(1), .DEPTH(NORM_PAD)) u_norm_dly (
    .clk(clk), .rst_n(rst_n), .d(ovr_norm_in), .q(norm_dly)
  );

  adcfmt_delay #(.W(1), .DEPTH(FAST_PAD)) u_fast_dly (
    .clk(clk), .rst_n(rst_n), .d(ovr_fast_in), .q(fast_dly)
  );

  adcfmt_shaper #(.W(WORD_W)) u_shaper (
    .clk(clk), .rst_n(rst_n), .raw(raw_dly),
    .fmt_offset(fmt_offset), .bit_flip(bit_flip), .word_q(shaped)
  );

  adcfmt_lane_pack #(.W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .word(shaped),
    .norm_flag(norm_dly), .fast_flag(fast_dly),
    .lsb_mode(lsb_mode), .ch_disable(ch_disable),
    .rise_q(lane_rise), .fall_q(lane_fall),
    .norm_pin_q(ovr_norm_pin), .fast_pin_q(ovr_fast_pin), .oe_q(lane_oe)
  );
endmodule

// File: rtl/adcfmt_checker.sv
module adcfmt_checker #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       lsb_mode,
  input logic             ch_disable,
  input logic [LANES-1:0] lane_rise,
  input logic [LANES-1:0] lane_fall,
  input logic             ovr_norm_pin,
  input logic             ovr_fast_pin,
  input logic             lane_oe
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (lane_rise == '0 && lane_fall == '0 &&
                             !ovr_norm_pin && !ovr_fast_pin && !lane_oe);
    end
  end

  // R10
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_disable |=> !lane_oe);

  // R10
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_disable |=> lane_oe);

  // R7
  lane0_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsb_mode == 2'b01 && $stable(lsb_mode)) |->
      (lane_rise[0] == ovr_fast_pin && lane_fall[0] == ovr_fast_pin));

  // R8
  lane0_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsb_mode == 2'b10 && $stable(lsb_mode)) |->
      (lane_rise[0] == ovr_norm_pin && lane_fall[0] == ovr_norm_pin));
endmodule

bind adc_ddr_formatter adcfmt_checker #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lsb_mode(lsb_mode), .ch_disable(ch_disable),
  .lane_rise(lane_rise), .lane_fall(lane_fall),
  .ovr_norm_pin(ovr_norm_pin), .ovr_fast_pin(ovr_fast_pin), .lane_oe(lane_oe)
);

// File: tb/adc_ddr_formatter_tb.sv
module adc_ddr_formatter_tb;
  localparam int DATA_LAT = 14;
  localparam int FAST_LAT = 9;

  typedef struct packed {
    logic [15:0] s;
    logic        n;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic [15:0] smp_code;
  logic        ovr_norm_in, ovr_fast_in, fmt_offset, bit_flip, ch_disable;
  logic [1:0]  lsb_mode;
  logic [7:0]  lane_rise, lane_fall;
  logic        ovr_norm_pin, ovr_fast_pin, lane_oe;

  adc_ddr_formatter u_dut (
    .clk(clk), .rst_n(rst_n), .smp_code(smp_code),
    .ovr_norm_in(ovr_norm_in), .ovr_fast_in(ovr_fast_in),
    .fmt_offset(fmt_offset), .bit_flip(bit_flip), .lsb_mode(lsb_mode),
    .ch_disable(ch_disable), .lane_rise(lane_rise), .lane_fall(lane_fall),
    .ovr_norm_pin(ovr_norm_pin), .ovr_fast_pin(ovr_fast_pin), .lane_oe(lane_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_chk = 0, n_bad = 0, ecnt = 0;
  bit    running = 1'b0, done = 1'b0;
  string ph_tag = "R6";
  item_t dq[$];
  logic  fq[$];
  logic  fnow = 1'b0;
  logic [31:0] lfsr = 32'h1234_ABCD;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Expected word from R4 and R5.
  function automatic logic [15:0] exp_word(input logic [15:0] s, input bit off, input bit fl);
    logic [15:0] w, r;
    w = s;
    if (!off) w[15] = ~w[15];
    for (int i = 0; i < 16; i++) r[i] = w[15-i];
    return fl ? r : w;
  endfunction

  task automatic drive(input logic [15:0] s, input logic n, input logic f);
    smp_code    = s;
    ovr_norm_in = n;
    ovr_fast_in = f;
    dq.push_back('{s: s, n: n});
    fq.push_back(f);
  endtask

  // Monitor: samples 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (running) begin
      ecnt++;
      chk("R10", {31'd0, lane_oe}, {31'd0, ~ch_disable});
      if (ecnt >= FAST_LAT && fq.size() > 0) begin
        fnow = fq.pop_front();
        chk("R3", {31'd0, ovr_fast_pin}, {31'd0, fnow});
      end
      if (ecnt >= DATA_LAT && dq.size() > 0) begin
        item_t it;
        logic [15:0] w;
        logic [7:0] er, ef;
        it = dq.pop_front();
        w = exp_word(it.s, fmt_offset, bit_flip);
        for (int k = 0; k < 8; k++) begin
          er[k] = w[2*k];
          ef[k] = w[2*k+1];
        end
        if (lsb_mode == 2'b01) begin er[0] = fnow; ef[0] = fnow; end
        if (lsb_mode == 2'b10) begin er[0] = it.n; ef[0] = it.n; end
        chk("R2", {31'd0, ovr_norm_pin}, {31'd0, it.n});
        chk(ph_tag, {24'd0, lane_rise}, {24'd0, er});
        chk(ph_tag, {24'd0, lane_fall}, {24'd0, ef});
      end
    end
  end

  task automatic run_phase(input string tag, input bit off, input bit fl,
                           input logic [1:0] m, input bit dis, input int n);
    logic [15:0] corner [6];
    corner = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001, 16'hAAAA};
    @(negedge clk);
    running = 1'b0;
    rst_n = 1'b0;
    fmt_offset = off; bit_flip = fl; lsb_mode = m; ch_disable = dis;
    smp_code = '0; ovr_norm_in = 1'b0; ovr_fast_in = 1'b0;
    ph_tag = tag;
    repeat (2) @(negedge clk);
    // R1: quiet outputs while held in reset
    chk("R1", {15'd0, lane_rise, lane_fall, 1'b0}, 32'd0);
    chk("R1", {29'd0, ovr_norm_pin, ovr_fast_pin, lane_oe}, 32'd0);
    dq.delete();
    fq.delete();
    ecnt = 0;
    fnow = 1'b0;
    rst_n = 1'b1;
    running = 1'b1;
    for (int i = 0; i < n + DATA_LAT; i++) begin
      if (i > 0) @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (i < 6)      drive(corner[i], lfsr[5], lfsr[9]);
      else if (i < n) drive(lfsr[15:0], lfsr[5], lfsr[9]);
      else            drive(16'h0000, 1'b0, 1'b0);
    end
    @(negedge clk);
    running = 1'b0;
  endtask

  initial begin
    rst_n = 1'b1;
    smp_code = '0; ovr_norm_in = 0; ovr_fast_in = 0;
    fmt_offset = 0; bit_flip = 0; lsb_mode = 2'b00; ch_disable = 0;
    #3 rst_n = 1'b0;
    run_phase("R6", 1'b0, 1'b0, 2'b00, 1'b0, 40);  // twos complement, R6 packing
    run_phase("R4", 1'b1, 1'b0, 2'b00, 1'b0, 40);  // offset binary pass-through
    run_phase("R5", 1'b0, 1'b1, 2'b00, 1'b0, 40);  // reversal after conversion
    run_phase("R5", 1'b1, 1'b1, 2'b00, 1'b0, 40);
    run_phase("R7", 1'b0, 1'b0, 2'b01, 1'b0, 40);  // fast flag on lane 0
    run_phase("R8", 1'b0, 1'b0, 2'b10, 1'b0, 40);  // normal flag on lane 0
    run_phase("R9", 1'b0, 1'b1, 2'b11, 1'b0, 40);  // code 11 keeps data
    run_phase("R10", 1'b1, 1'b0, 2'b00, 1'b1, 30); // disabled, data continues
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule